// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds a set of event counters for one processor core. It has a parameterised number of general counters, each steered by its own event-select register, and a set of fixed counters, each tied to one dedicated event input and steered by a 4-bit field in one shared control register. Every cycle the core presents a small increment value for each selectable event and for each fixed event, together with the current privilege level. A counter adds to its value only when its local controls, the privilege level and its bit in a bank-wide enable register all allow it.

When a counter passes its all-ones value and wraps, a sticky bit in the overflow status register is set at that counter's global position: general counter i sits at position i, fixed counter j at position 32+j. The enable register uses the same positions. Software clears status bits by writing ones to a clear register. An interrupt output stays high while any status bit is set for a counter that has its interrupt enable on. Software can read and write every counter at any time through a simple register port. Reads are combinational and writes take effect at the next clock edge.

Top module: `pmc_bank`

## Requirements
- R1: A general counter advances only when the enable bit (bit 22) of its event-select register is 1 and its bit in the global enable register (address 0x31) is 1. If either is 0, its value holds.
- R2: Fixed counter j is controlled by the 4-bit field at bits [4j+3:4j] of the fixed control register (address 0x30). Field bit 0 permits counting in kernel mode, bit 1 permits counting in user mode, and bit 3 enables the overflow interrupt. A field of zero stops the counter. Fixed counter j uses global index 32+j.
- R3: The `priv_user` input is 1 in user mode and 0 in kernel mode. A general counter counts in user mode only if event-select bit 16 is 1, and in kernel mode only if bit 17 is 1.
- R4: Event-select bits [7:0] choose which `evt_inc` lane feeds the counter. A code at or above NUM_EVT counts nothing. Bits [15:8] are stored and read back but do not affect the choice.
- R5: When a counter wraps past all-ones, the status bit (address 0x32) at its global index is set. The bit stays set until a clear write removes it.
- R6: A write to the clear register (address 0x33) clears each status bit whose written bit is 1 and leaves the other bits as they were. Reading 0x33 returns 0. An overflow in the same cycle as a clear write keeps its bit set.
- R7: `ovf_irq` is high exactly while some status bit is set whose counter has its interrupt enable on (event-select bit 20, or fixed field bit 3). An overflow without interrupt enable sets status only.
- R8: A counter preset to 1−N (modulo 2^CNT_W) that then counts N single events wraps and holds exactly 1.
- R9: A non-zero threshold in event-select bits [31:24] makes the counter add 1 in each cycle whose lane increment is at least the threshold, and 0 otherwise. A zero threshold adds the lane increment itself.
- R10: A write to a running counter replaces its value at the next edge, and counting then continues from the written value.
- R11: When a counter write and an increment fall in the same cycle, the written value is stored and that cycle's increment is lost.
- R12: Counters are CNT_W bits wide, and writes keep only the low CNT_W bits. Enable and status bits for counters that do not exist read as 0. Counter and event-select addresses beyond the implemented counters read 0 and ignore writes.
- R13: After reset, all counters, controls, enable and status bits are 0 and `ovf_irq` is low.
- R14: The register map is: general counters at 0x00+i, event selects at 0x10+i, fixed counters at 0x20+j, and the control registers at 0x30–0x33. `reg_rdata` reflects `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_inc | input | NUM_EVT*INC_W | Per-cycle increment of each selectable event lane, lane e in bits [e*INC_W +: INC_W] |
| fx_inc | input | NUM_FX*INC_W | Per-cycle increment of each fixed event, counter j in bits [j*INC_W +: INC_W] |
| priv_user | input | 1 | 1 = user mode, 0 = kernel mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| ovf_irq | output | 1 | Overflow interrupt, level |

## Verification
The bound checker checks, on every cycle, that status bits never drop without a clear write, that unimplemented enable and status bits stay 0, that the interrupt is never high while status is empty, that an enable write lands masked, and that the status address reads back the status register. The counting behaviour needs the bench's scenarios: the gating by local enable, global enable and privilege, lane selection, the threshold mode, the exact wrap to 1 from a preset, the write that wins over an increment, and the fixed control fields.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

    localparam int DATA_W  = 64;
    localparam int FX_BASE = 32;

    // register map
    localparam logic [7:0] A_GP_CNT0  = 8'h00;
    localparam logic [7:0] A_EVSEL0   = 8'h10;
    localparam logic [7:0] A_FX_CNT0  = 8'h20;
    localparam logic [7:0] A_FX_CTL   = 8'h30;
    localparam logic [7:0] A_GLB_EN   = 8'h31;
    localparam logic [7:0] A_OVF_STAT = 8'h32;
    localparam logic [7:0] A_OVF_CLR  = 8'h33;

    // event-select bit positions
    localparam int EV_USR = 16;
    localparam int EV_KRN = 17;
    localparam int EV_IE  = 20;
    localparam int EV_EN  = 22;
    localparam int EV_TH  = 24;

    typedef enum logic [2:0] {
        RG_GPCNT, RG_EVSEL, RG_FXCNT, RG_FXCTL,
        RG_GEN, RG_STAT, RG_CLR, RG_NONE
    } region_e;

    typedef struct packed {
        logic    we;
        region_e rg;
        logic [3:0] idx;
    } acc_t;

    function automatic region_e decode_region(input logic [7:0] a);
        region_e r;
        case (a[7:4])
            4'h0: r = RG_GPCNT;
            4'h1: r = RG_EVSEL;
            4'h2: r = RG_FXCNT;
            4'h3: begin
                case (a[3:0])
                    4'h0:    r = RG_FXCTL;
                    4'h1:    r = RG_GEN;
                    4'h2:    r = RG_STAT;
                    4'h3:    r = RG_CLR;
                    default: r = RG_NONE;
                endcase
            end
            default: r = RG_NONE;
        endcase
        return r;
    endfunction

    function automatic logic priv_ok(input logic usr_en, input logic krn_en,
                                     input logic is_user);
        return is_user ? usr_en : krn_en;
    endfunction

    function automatic logic [DATA_W-1:0] impl_mask(input int ngp, input int nfx);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < ngp; i++) m[i] = 1'b1;
        for (int j = 0; j < nfx; j++) m[FX_BASE + j] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pmc_counter.sv
`timescale 1ns/1ps
module pmc_counter #(
    parameter int CNT_W = 48,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [INC_W-1:0] inc,
    input  logic [7:0]       thresh,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] value,
    output logic             wrap
);
    localparam int CW = (INC_W > 8) ? INC_W : 8;

    logic [CW-1:0]  inc_x, th_x;
    logic [CNT_W:0] step, sum;

    always_comb begin
        inc_x = CW'(inc);
        th_x  = CW'(thresh);
        if (th_x == '0) step = (CNT_W+1)'(inc);
        else            step = (inc_x >= th_x) ? (CNT_W+1)'(1) : '0;
        sum  = {1'b0, value} + step;
        // a software write in the same cycle wins: no wrap recorded
        wrap = run && !wr_en && sum[CNT_W];
    end

    always_ff @(posedge clk) begin
        if (rst)        value <= '0;
        else if (wr_en) value <= wr_val;
        else if (run)   value <= sum[CNT_W-1:0];
    end
endmodule

// File: rtl/pmc_gp_slot.sv
`timescale 1ns/1ps
module pmc_gp_slot
    import pmc_pkg::*;
#(
    parameter int CNT_W   = 48,
    parameter int INC_W   = 4,
    parameter int NUM_EVT = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_EVT*INC_W-1:0] evt_inc,
    input  logic                     priv_user,
    input  logic                     glob_en,
    input  logic                     sel_we,
    input  logic [31:0]              sel_wval,
    input  logic                     cnt_we,
    input  logic [CNT_W-1:0]         cnt_wval,
    output logic [31:0]              sel_q,
    output logic [CNT_W-1:0]         value,
    output logic                     wrap,
    output logic                     irq_en
);
    logic [INC_W-1:0] src;
    logic             run;

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= '0;
        else if (sel_we) sel_q <= sel_wval;
    end

    // lane pick from the low code byte; unmatched codes feed zero
    always_comb begin
        src = '0;
        for (int e = 0; e < NUM_EVT; e++)
            if (sel_q[7:0] == 8'(e)) src = evt_inc[e*INC_W +: INC_W];
    end

    assign run    = sel_q[EV_EN] && glob_en &&
                    priv_ok(sel_q[EV_USR], sel_q[EV_KRN], priv_user);
    assign irq_en = sel_q[EV_IE];

    pmc_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .inc    (src),
        .thresh (sel_q[EV_TH +: 8]),
        .wr_en  (cnt_we),
        .wr_val (cnt_wval),
        .value  (value),
        .wrap   (wrap)
    );
endmodule

// File: rtl/pmc_bank.sv
`timescale 1ns/1ps
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int NUM_GP  = 4,
    parameter int NUM_FX  = 3,
    parameter int CNT_W   = 48,
    parameter int NUM_EVT = 8,
    parameter int INC_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_EVT*INC_W-1:0] evt_inc,
    input  logic [NUM_FX*INC_W-1:0]  fx_inc,
    input  logic                     priv_user,
    input  logic                     reg_we,
    input  logic [7:0]               reg_addr,
    input  logic [63:0]              reg_wdata,
    output logic [63:0]              reg_rdata,
    output logic                     ovf_irq
);
    localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_GP, NUM_FX);
    localparam int FXW = 4 * NUM_FX;

    acc_t acc;
    assign acc = '{we: reg_we, rg: decode_region(reg_addr), idx: reg_addr[3:0]};

    logic [DATA_W-1:0] gen_en_q, status_q, set_vec, irq_mask, clr_vec;
    logic [FXW-1:0]    fx_ctl_q;

    logic [31:0]      gp_sel  [NUM_GP];
    logic [CNT_W-1:0] gp_val  [NUM_GP];
    logic             gp_wrap [NUM_GP];
    logic             gp_ie   [NUM_GP];
    logic [CNT_W-1:0] fx_val  [NUM_FX];
    logic             fx_wrap [NUM_FX];

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        logic sel_we, cnt_we;
        assign sel_we = acc.we && acc.rg == RG_EVSEL && acc.idx == 4'(g);
        assign cnt_we = acc.we && acc.rg == RG_GPCNT && acc.idx == 4'(g);
        pmc_gp_slot #(.CNT_W(CNT_W), .INC_W(INC_W), .NUM_EVT(NUM_EVT)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .evt_inc   (evt_inc),
            .priv_user (priv_user),
            .glob_en   (gen_en_q[g]),
            .sel_we    (sel_we),
            .sel_wval  (reg_wdata[31:0]),
            .cnt_we    (cnt_we),
            .cnt_wval  (reg_wdata[CNT_W-1:0]),
            .sel_q     (gp_sel[g]),
            .value     (gp_val[g]),
            .wrap      (gp_wrap[g]),
            .irq_en    (gp_ie[g])
        );
    end

    for (genvar j = 0; j < NUM_FX; j++) begin : g_fx
        logic run, cnt_we;
        assign run = gen_en_q[FX_BASE + j] &&
                     priv_ok(fx_ctl_q[4*j + 1], fx_ctl_q[4*j], priv_user);
        assign cnt_we = acc.we && acc.rg == RG_FXCNT && acc.idx == 4'(j);
        pmc_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .inc    (fx_inc[j*INC_W +: INC_W]),
            .thresh (8'd0),
            .wr_en  (cnt_we),
            .wr_val (reg_wdata[CNT_W-1:0]),
            .value  (fx_val[j]),
            .wrap   (fx_wrap[j])
        );
    end

    always_comb begin
        set_vec  = '0;
        irq_mask = '0;
        for (int i = 0; i < NUM_GP; i++) begin
            set_vec[i]  = gp_wrap[i];
            irq_mask[i] = gp_ie[i];
        end
        for (int j = 0; j < NUM_FX; j++) begin
            set_vec[FX_BASE + j]  = fx_wrap[j];
            irq_mask[FX_BASE + j] = fx_ctl_q[4*j + 3];
        end
        clr_vec = (acc.we && acc.rg == RG_CLR) ? reg_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en_q <= '0;
            fx_ctl_q <= '0;
            status_q <= '0;
        end else begin
            if (acc.we && acc.rg == RG_GEN)   gen_en_q <= reg_wdata & IMPL;
            if (acc.we && acc.rg == RG_FXCTL) fx_ctl_q <= reg_wdata[FXW-1:0];
            // a fresh wrap outranks a clear in the same cycle
            status_q <= ((status_q & ~clr_vec) | set_vec) & IMPL;
        end
    end

    assign ovf_irq = |(status_q & irq_mask);

    always_comb begin
        reg_rdata = '0;
        case (acc.rg)
            RG_GPCNT: for (int i = 0; i < NUM_GP; i++)
                          if (acc.idx == 4'(i)) reg_rdata = 64'(gp_val[i]);
            RG_EVSEL: for (int i = 0; i < NUM_GP; i++)
                          if (acc.idx == 4'(i)) reg_rdata = 64'(gp_sel[i]);
            RG_FXCNT: for (int j = 0; j < NUM_FX; j++)
                          if (acc.idx == 4'(j)) reg_rdata = 64'(fx_val[j]);
            RG_FXCTL: reg_rdata = 64'(fx_ctl_q);
            RG_GEN:   reg_rdata = gen_en_q;
            RG_STAT:  reg_rdata = status_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmc_bank_chk.sv
`timescale 1ns/1ps
module pmc_bank_chk
    import pmc_pkg::*;
#(
    parameter int NUM_GP = 4,
    parameter int NUM_FX = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [63:0] reg_wdata,
    input logic [63:0] reg_rdata,
    input logic        ovf_irq,
    input logic [63:0] status,
    input logic [63:0] gen_en
);
    localparam logic [63:0] IMPL = impl_mask(NUM_GP, NUM_FX);

    // R5: without a clear write, no status bit may fall
    a_r5_sticky_status: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == A_OVF_CLR) |=> ((status & $past(status)) == $past(status)));

    // R12: bits for absent counters stay zero
    a_r12_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
        ((status & ~IMPL) == '0) && ((gen_en & ~IMPL) == '0));

    // R7: interrupt needs a pending status bit
    a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
        ovf_irq |-> (status != '0));

    // R1: global enable write lands, limited to existing counters
    a_r1_gen_write: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_GLB_EN) |=> (gen_en == ($past(reg_wdata) & IMPL)));

    // R14: status address returns status in the same cycle
    a_r14_status_read: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_OVF_STAT) |-> (reg_rdata == status));
endmodule

bind pmc_bank pmc_bank_chk #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ovf_irq   (ovf_irq),
    .status    (status_q),
    .gen_en    (gen_en_q)
);

// File: tb/tb_pmc_bank.sv
`timescale 1ns/1ps
module tb_pmc_bank;
    localparam int NUM_GP = 4, NUM_FX = 3, CNT_W = 48, NUM_EVT = 8, INC_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_EVT*INC_W-1:0] evt_inc = '0;
    logic [NUM_FX*INC_W-1:0]  fx_inc = '0;
    logic        priv_user = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        ovf_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pmc_bank #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .CNT_W(CNT_W),
               .NUM_EVT(NUM_EVT), .INC_W(INC_W)) dut (
        .clk(clk), .rst(rst), .evt_inc(evt_inc), .fx_inc(fx_inc),
        .priv_user(priv_user), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_irq(ovf_irq));

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [63:0] evsel(input int code, input bit usr, input bit krn,
                                         input bit ie, input bit en, input int th);
        logic [63:0] v;
        v = 64'(code & 16'hFFFF);
        v[16] = usr; v[17] = krn; v[20] = ie; v[22] = en;
        v[31:24] = 8'(th);
        return v;
    endfunction

    task automatic drive_evt(input int e, input logic [3:0] v, input int n);
        @(negedge clk);
        evt_inc[e*INC_W +: INC_W] = v;
        repeat (n) @(negedge clk);
        evt_inc = '0;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rd(8'h32, d); check("R13 status", d, 64'h0);
        rd(8'h31, d); check("R13 enable", d, 64'h0);
        rd(8'h00, d); check("R13 counter", d, 64'h0);
        check("R13 irq", 64'(ovf_irq), 64'h0);
    endtask

    task automatic t_map();
        logic [63:0] d;
        wr(8'h31, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h31, d); check("R12 enable mask", d, 64'h0000_0007_0000_000F);
        wr(8'h31, 64'h0);
        wr(8'h05, 64'd123);
        rd(8'h05, d); check("R12 absent counter", d, 64'h0);
        wr(8'h00, 64'hFFFF_0123_4567_89AB);
        rd(8'h00, d); check("R12 truncation", d, 64'h0000_0123_4567_89AB);
        rd(8'h33, d); check("R6 clear reads zero", d, 64'h0);
        wr(8'h00, 64'h0);
    endtask

    task automatic t_enable();
        logic [63:0] d;
        priv_user = 1'b1;
        wr(8'h10, evsel(2, 1, 1, 0, 1, 0));
        drive_evt(2, 4'd1, 5);
        rd(8'h00, d); check("R1 global off", d, 64'd0);
        wr(8'h31, 64'h1);
        drive_evt(2, 4'd3, 5);
        rd(8'h00, d); check("R1 both on", d, 64'd15);
        wr(8'h10, evsel(2, 1, 1, 0, 0, 0));
        drive_evt(2, 4'd1, 4);
        rd(8'h00, d); check("R1 local off", d, 64'd15);
    endtask

    task automatic t_priv();
        logic [63:0] d;
        wr(8'h31, 64'h2);
        wr(8'h11, evsel(4, 1, 0, 0, 1, 0));
        priv_user = 1'b0;
        drive_evt(4, 4'd2, 4);
        rd(8'h01, d); check("R3 kernel blocked", d, 64'd0);
        priv_user = 1'b1;
        drive_evt(4, 4'd2, 4);
        rd(8'h01, d); check("R3 user counts", d, 64'd8);
        wr(8'h11, evsel(9, 1, 0, 0, 1, 0));
        drive_evt(4, 4'd2, 3);
        rd(8'h01, d); check("R4 code beyond lanes", d, 64'd8);
        wr(8'h11, evsel(16'h0104, 1, 0, 0, 1, 0));
        drive_evt(4, 4'd1, 3);
        rd(8'h01, d); check("R4 upper byte ignored", d, 64'd11);
        drive_evt(3, 4'd1, 3);
        rd(8'h01, d); check("R4 other lane ignored", d, 64'd11);
    endtask

    task automatic t_fixed();
        logic [63:0] d;
        wr(8'h31, 64'h0000_0003_0000_0000);
        wr(8'h30, 64'h20);
        priv_user = 1'b1;
        @(negedge clk); fx_inc = {4'd0, 4'd1, 4'd1};
        repeat (6) @(negedge clk); fx_inc = '0;
        rd(8'h21, d); check("R2 user field", d, 64'd6);
        rd(8'h20, d); check("R2 zero field", d, 64'd0);
        priv_user = 1'b0;
        @(negedge clk); fx_inc = {4'd0, 4'd1, 4'd0};
        repeat (3) @(negedge clk); fx_inc = '0;
        rd(8'h21, d); check("R2 kernel blocked", d, 64'd6);
        wr(8'h30, 64'h10);
        @(negedge clk); fx_inc = {4'd0, 4'd1, 4'd0};
        repeat (2) @(negedge clk); fx_inc = '0;
        rd(8'h21, d); check("R2 kernel field", d, 64'd8);
        priv_user = 1'b1;
        wr(8'h30, 64'h0);
    endtask

    task automatic t_thresh();
        logic [63:0] d;
        logic [3:0] pat [5];
        pat = '{4'd1, 4'd2, 4'd3, 4'd0, 4'd2};
        wr(8'h31, 64'h1);
        wr(8'h00, 64'h0);
        wr(8'h10, evsel(2, 1, 1, 0, 1, 2));
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); evt_inc[2*INC_W +: INC_W] = pat[k];
        end
        @(negedge clk); evt_inc = '0;
        rd(8'h00, d); check("R9 threshold two", d, 64'd3);
        wr(8'h00, 64'h0);
        wr(8'h10, evsel(2, 1, 1, 0, 1, 0));
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); evt_inc[2*INC_W +: INC_W] = pat[k];
        end
        @(negedge clk); evt_inc = '0;
        rd(8'h00, d); check("R9 threshold zero", d, 64'd8);
    endtask

    task automatic t_live();
        logic [63:0] d;
        @(negedge clk);
        evt_inc[2*INC_W +: INC_W] = 4'd1;
        reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 64'd100;
        @(negedge clk);
        reg_we = 1'b0;
        rd(8'h00, d); check("R11 write wins", d, 64'd100);
        repeat (3) @(negedge clk);
        evt_inc = '0;
        rd(8'h00, d); check("R10 continues", d, 64'd103);
        wr(8'h31, 64'h0);
    endtask

    task automatic t_overflow();
        logic [63:0] d;
        wr(8'h33, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(8'h12, evsel(0, 1, 1, 0, 1, 0));
        wr(8'h13, evsel(0, 1, 1, 1, 1, 0));
        wr(8'h02, 64'h0000_FFFF_FFFF_FFF7);
        wr(8'h03, 64'h0000_FFFF_FFFF_FFF7);
        wr(8'h31, 64'hC);
        drive_evt(0, 4'd1, 10);
        rd(8'h02, d); check("R8 wrap to one", d, 64'd1);
        rd(8'h03, d); check("R8 wrap to one ie", d, 64'd1);
        rd(8'h32, d); check("R5 status set", d, 64'hC);
        check("R7 irq raised", 64'(ovf_irq), 64'h1);
        wr(8'h33, 64'h8);
        rd(8'h32, d); check("R6 partial clear", d, 64'h4);
        check("R7 no irq without enable", 64'(ovf_irq), 64'h0);
        repeat (3) @(negedge clk);
        rd(8'h32, d); check("R5 sticky", d, 64'h4);
        wr(8'h33, 64'h4);
        rd(8'h32, d); check("R6 clear all", d, 64'h0);
        wr(8'h31, 64'h0000_0001_0000_0000);
        wr(8'h30, 64'hB);
        wr(8'h20, 64'h0000_FFFF_FFFF_FFFE);
        @(negedge clk); fx_inc = {4'd0, 4'd0, 4'd3};
        @(negedge clk); fx_inc = '0;
        rd(8'h20, d); check("R2 fixed wrap", d, 64'd1);
        rd(8'h32, d); check("R5 fixed index", d, 64'h0000_0001_0000_0000);
        check("R7 fixed irq", 64'(ovf_irq), 64'h1);
        wr(8'h33, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h32, d); check("R6 fixed clear", d, 64'h0);
        check("R7 irq drops", 64'(ovf_irq), 64'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_enable();
        t_priv();
        t_fixed();
        t_thresh();
        t_live();
        t_overflow();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule